// File: doc/BRIEF.md
# Serial Test-Pattern Transmit Source

This block is the transmit side of a bit-error-rate tester. Each transmit clock it emits one test bit. The bit comes from one of three sources: a pseudorandom shift-register sequence whose length and feedback tap are set at run time, a fixed word that is shifted out over and over, or a 20-stage pseudorandom sequence whose runs of zeros are capped. An inversion control complements the serial output as it leaves the block.

Software sets the pattern inputs and then raises the load control. The rising edge is registered, and that same edge takes a snapshot of the pattern inputs, seeds the generator and selects the mode. This is well inside the four-clock window in which the inputs must be held steady. If the load control stays high, no further loads happen. A new load needs the control to drop to 0 and rise again.

Top module: `tpat_tx_gen`

## Requirements
- R1: On the clock edge where `load_req` is 1 and was 0 at the previous edge, the block captures the pattern inputs and seeds the generator. `dout` holds the first pattern bit after the next edge, and one new bit follows on each later edge.
- R2: While `load_req` stays high after its rising edge, and while it is low, changes on the pattern inputs have no effect. The running sequence continues unchanged.
- R3: At load time the mode is chosen in this order. `cfg_qrss`=1 selects the capped 20-stage sequence. Otherwise `cfg_prbs_sel`=1 selects the programmable pseudorandom mode. Otherwise the repetitive mode is selected.
- R4: In repetitive mode the bits `cfg_word[cfg_len:0]` are sent cyclically, starting with bit 0. The higher word bits are ignored.
- R5: In pseudorandom mode the register has `cfg_len`+1 stages, s[0]..s[len]. Seed bit i of `cfg_word` goes into s[i]. The output is s[len]. Each clock, s shifts toward the higher index and s[0] takes s[len] XOR s[tap]. The tap must be below the length.
- R6: In either pseudorandom mode, a seed that is zero within the active stages is replaced by all ones in those stages.
- R7: The capped mode uses 20 stages, with feedback from s[19] XOR s[16]. It is seeded from `cfg_word[19:0]`. `cfg_len` and `cfg_tap` are ignored in this mode.
- R8: In the capped mode `dout` (before inversion) never shows 14 zeros in a row. A zero that would become the 14th is sent as 1, and the run count restarts.
- R9: When `invert`=1, every output bit is the complement of the generated bit. `invert` acts on `dout` at once, with no clock delay.
- R10: Reset clears all state. Until the first load, `dout` equals `invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_qrss | input | 1 | Select the capped 20-stage sequence |
| cfg_prbs_sel | input | 1 | 1 = pseudorandom, 0 = repetitive word |
| cfg_len | input | 5 | Stage count or word length, minus one |
| cfg_tap | input | 5 | Feedback stage index (stage minus one) |
| cfg_word | input | 32 | Seed or repeated pattern word |
| load_req | input | 1 | Load on rising edge |
| invert | input | 1 | Complement the serial output |
| dout | output | 1 | Serial test bit |

## Verification
Two repetitive words are sent. One is an 8-bit word. The other is a 3-bit word whose upper word bits are set, which shows whether the length mask takes effect. Two pseudorandom sequences are compared bit by bit with a model: a 7-stage sequence with a mixed seed, and a 5-stage sequence with a zero seed. The zero seed tells the lock-up substitution apart from a plain seed load. The capped mode is seeded with a single 1, so the raw sequence starts with a long run of zeros that forces the cap. In that run `cfg_prbs_sel` is also high, which tests the mode priority. The remaining runs cover the inversion control, a change of inversion partway through a run, and a load control held high while the pattern inputs change.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic [1:0] {
        MODE_RPT  = 2'd0,
        MODE_PRBS = 2'd1,
        MODE_QRSS = 2'd2
    } mode_e;
endpackage

// File: rtl/tpg_rise_detect.sv
module tpg_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
        rise   = level & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/tpg_lfsr_step.sv
module tpg_lfsr_step #(
    parameter int W  = 32,
    parameter int LW = 5
) (
    input  logic [W-1:0]  state,
    input  logic [LW-1:0] len,
    input  logic [LW-1:0] tap,
    output logic [W-1:0]  next_state,
    output logic          out_bit
);
    logic fb;

    assign out_bit = state[len];
    assign fb      = state[len] ^ state[tap];

    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign next_state[i] = fb;
        end else begin : g_body
            assign next_state[i] = (LW'(i) <= len) ? state[i-1] : 1'b0;
        end
    end
endmodule

// File: rtl/tpg_rotate_step.sv
module tpg_rotate_step #(
    parameter int W  = 32,
    parameter int LW = 5
) (
    input  logic [W-1:0]  state,
    input  logic [LW-1:0] len,
    output logic [W-1:0]  next_state,
    output logic          out_bit
);
    assign out_bit = state[0];

    for (genvar i = 0; i < W; i++) begin : g_pos
        if (i < W - 1) begin : g_mid
            assign next_state[i] = (LW'(i) == len) ? state[0] :
                                   (LW'(i) <  len) ? state[i+1] : 1'b0;
        end else begin : g_top
            assign next_state[i] = (LW'(i) == len) ? state[0] : 1'b0;
        end
    end
endmodule

// File: rtl/tpg_zero_guard.sv
module tpg_zero_guard #(
    parameter int RUN_MAX = 14,
    parameter int CW      = 4
) (
    input  logic          raw,
    input  logic [CW-1:0] cnt,
    output logic          out_bit,
    output logic [CW-1:0] cnt_next
);
    always_comb begin
        if (!raw && cnt == CW'(RUN_MAX - 1)) begin
            out_bit  = 1'b1;
            cnt_next = '0;
        end else if (!raw) begin
            out_bit  = 1'b0;
            cnt_next = cnt + 1'b1;
        end else begin
            out_bit  = 1'b1;
            cnt_next = '0;
        end
    end
endmodule

// File: rtl/tpat_tx_gen.sv
module tpat_tx_gen
    import tpg_pkg::*;
#(
    parameter  int W           = 32,
    parameter  int QRSS_STAGES = 20,
    parameter  int QRSS_TAP    = 17,
    parameter  int ZRUN_MAX    = 14,
    localparam int LW          = $clog2(W),
    localparam int ZCW         = $clog2(ZRUN_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_qrss,
    input  logic          cfg_prbs_sel,
    input  logic [LW-1:0] cfg_len,
    input  logic [LW-1:0] cfg_tap,
    input  logic [W-1:0]  cfg_word,
    input  logic          load_req,
    input  logic          invert,
    output logic          dout
);
    typedef struct packed {
        mode_e          mode;
        logic [LW-1:0]  len;
        logic [LW-1:0]  tap;
        logic [W-1:0]   sr;
        logic [ZCW-1:0] zc;
        logic           obit;
    } st_t;

    localparam logic [W-1:0] QMASK = {{(W-QRSS_STAGES){1'b0}}, {QRSS_STAGES{1'b1}}};

    st_t st_d, st_q;

    logic           load_rise;
    logic [W-1:0]   lfsr_next, rot_next, len_mask, seed;
    logic           lfsr_bit, rot_bit, guard_bit;
    logic [ZCW-1:0] guard_cnt;

    // bind-visible views of the state
    mode_e          mode_q;
    logic [LW-1:0]  len_q, tap_q;
    logic [W-1:0]   sr_q;
    logic           bit_q;

    tpg_rise_detect u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (load_req),
        .rise  (load_rise)
    );

    tpg_lfsr_step #(.W(W), .LW(LW)) u_lfsr (
        .state      (st_q.sr),
        .len        (st_q.len),
        .tap        (st_q.tap),
        .next_state (lfsr_next),
        .out_bit    (lfsr_bit)
    );

    tpg_rotate_step #(.W(W), .LW(LW)) u_rot (
        .state      (st_q.sr),
        .len        (st_q.len),
        .next_state (rot_next),
        .out_bit    (rot_bit)
    );

    tpg_zero_guard #(.RUN_MAX(ZRUN_MAX), .CW(ZCW)) u_guard (
        .raw      (lfsr_bit),
        .cnt      (st_q.zc),
        .out_bit  (guard_bit),
        .cnt_next (guard_cnt)
    );

    // active-stage mask for the programmed length
    always_comb begin
        for (int i = 0; i < W; i++) begin
            len_mask[i] = (i <= int'(cfg_len));
        end
    end

    // seed selection, zero seed replaced in the pseudorandom modes
    always_comb begin
        if (cfg_qrss) begin
            seed = cfg_word & QMASK;
            if (seed == '0) seed = QMASK;
        end else if (cfg_prbs_sel) begin
            seed = cfg_word & len_mask;
            if (seed == '0) seed = len_mask;
        end else begin
            seed = cfg_word & len_mask;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_PRBS: begin
                st_d.sr   = lfsr_next;
                st_d.obit = lfsr_bit;
            end
            MODE_QRSS: begin
                st_d.sr   = lfsr_next;
                st_d.obit = guard_bit;
                st_d.zc   = guard_cnt;
            end
            default: begin
                st_d.sr   = rot_next;
                st_d.obit = rot_bit;
            end
        endcase

        if (load_rise) begin
            st_d.sr   = seed;
            st_d.zc   = '0;
            st_d.obit = 1'b0;
            if (cfg_qrss) begin
                st_d.mode = MODE_QRSS;
                st_d.len  = LW'(QRSS_STAGES - 1);
                st_d.tap  = LW'(QRSS_TAP - 1);
            end else begin
                st_d.mode = cfg_prbs_sel ? MODE_PRBS : MODE_RPT;
                st_d.len  = cfg_len;
                st_d.tap  = cfg_tap;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_q = st_q.mode;
    assign len_q  = st_q.len;
    assign tap_q  = st_q.tap;
    assign sr_q   = st_q.sr;
    assign bit_q  = st_q.obit;

    assign dout = st_q.obit ^ invert;
endmodule

// File: rtl/tpat_tx_chk.sv
module tpat_tx_chk
    import tpg_pkg::*;
#(
    parameter  int W        = 32,
    parameter  int ZRUN_MAX = 14,
    localparam int LW       = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_qrss,
    input logic [LW-1:0] cfg_len,
    input logic          load_req,
    input logic          invert,
    input logic          dout,
    input mode_e         mode_q,
    input logic [LW-1:0] len_q,
    input logic [LW-1:0] tap_q,
    input logic [W-1:0]  sr_q,
    input logic          bit_q
);
    logic ld_prev, rise, rise_q;
    int   zrun;

    assign rise = load_req && !ld_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_prev <= 1'b0;
            rise_q  <= 1'b0;
            zrun    <= 0;
        end else begin
            ld_prev <= load_req;
            rise_q  <= rise;
            if (rise || rise_q || mode_q != MODE_QRSS || bit_q) zrun <= 0;
            else                                                zrun <= zrun + 1;
        end
    end

    // R1: length captured from the pins on a load edge
    a_r1_len_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !cfg_qrss) |=> len_q == $past(cfg_len));

    // R3: capped mode wins at load
    a_r3_qrss_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && cfg_qrss) |=> mode_q == MODE_QRSS);

    // R4: rotation keeps the pattern weight
    a_r4_rotate_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RPT && !rise) |=> $countones(sr_q) == $past($countones(sr_q)));

    // R6: pseudorandom register never empties
    a_r6_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_RPT && tap_q != len_q) |-> sr_q != '0);

    // R8: zero runs in capped mode stay below the limit
    a_r8_zero_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_QRSS && !rise_q && !bit_q) |-> zrun < ZRUN_MAX - 1);

    // R9: toggling inversion flips the output immediately
    a_r9_invert_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(invert) && $stable(bit_q)) |-> !$stable(dout));
endmodule

bind tpat_tx_gen tpat_tx_chk #(.W(W), .ZRUN_MAX(ZRUN_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_qrss (cfg_qrss),
    .cfg_len  (cfg_len),
    .load_req (load_req),
    .invert   (invert),
    .dout     (dout),
    .mode_q   (mode_q),
    .len_q    (len_q),
    .tap_q    (tap_q),
    .sr_q     (sr_q),
    .bit_q    (bit_q)
);

// File: tb/sim_tpat_tx_gen.sv
module sim_tpat_tx_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_qrss = 1'b0;
    logic        cfg_prbs_sel = 1'b0;
    logic [4:0]  cfg_len = '0;
    logic [4:0]  cfg_tap = '0;
    logic [31:0] cfg_word = '0;
    logic        load_req = 1'b0;
    logic        invert = 1'b0;
    logic        dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [31:0] rs;
    int rl, rt, rmode, rz;

    always #2 clk = ~clk;

    tpat_tx_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_qrss(cfg_qrss), .cfg_prbs_sel(cfg_prbs_sel),
        .cfg_len(cfg_len), .cfg_tap(cfg_tap), .cfg_word(cfg_word),
        .load_req(load_req), .invert(invert), .dout(dout)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: dout=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic ref_load(bit q, bit p, int len, int tap, logic [31:0] word);
        logic [31:0] m;
        m  = (len == 31) ? 32'hFFFF_FFFF : ((32'd1 << (len + 1)) - 32'd1);
        rz = 0;
        if (q) begin
            rmode = 2; rl = 19; rt = 16;
            rs = word & 32'h000F_FFFF;
            if (rs == 0) rs = 32'h000F_FFFF;
        end else if (p) begin
            rmode = 1; rl = len; rt = tap;
            rs = word & m;
            if (rs == 0) rs = m;
        end else begin
            rmode = 0; rl = len; rt = tap;
            rs = word & m;
        end
    endtask

    task automatic ref_step(output logic b);
        logic fb;
        logic [31:0] m;
        m = (rl == 31) ? 32'hFFFF_FFFF : ((32'd1 << (rl + 1)) - 32'd1);
        if (rmode == 0) begin
            b  = rs[0];
            rs = (rs >> 1);
            rs[rl] = b;
        end else begin
            b  = rs[rl];
            fb = rs[rl] ^ rs[rt];
            rs = ((rs << 1) | {31'd0, fb}) & m;
            if (rmode == 2) begin
                if (!b && rz == 13) begin b = 1'b1; rz = 0; end
                else if (!b)        rz++;
                else                rz = 0;
            end
        end
    endtask

    task automatic do_load(bit q, bit p, int len, int tap, logic [31:0] word, bit keep);
        @(negedge clk);
        cfg_qrss = q; cfg_prbs_sel = p;
        cfg_len = 5'(len); cfg_tap = 5'(tap); cfg_word = word;
        load_req = 1'b1;
        ref_load(q, p, len, tap, word);
        @(negedge clk);
        if (!keep) load_req = 1'b0;
    endtask

    task automatic run(int n, string tag);
        logic b;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_step(b);
            chk(tag, dout, b ^ invert);
        end
    endtask

    // R10 and R9: reset state
    task automatic t_reset();
        #1;
        chk("R10 reset dout", dout, 1'b0);
        invert = 1'b1; #1;
        chk("R9 R10 reset inverted", dout, 1'b1);
        invert = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 idle after reset", dout, 1'b0);
    endtask

    // R4, R1: 8-bit repeated word
    task automatic t_repeat_long();
        do_load(1'b0, 1'b0, 7, 0, 32'h0000_00B5, 1'b0);
        run(24, "R4 R1 repeat 8-bit");
    endtask

    // R4: short word, upper bits ignored
    task automatic t_repeat_short();
        do_load(1'b0, 1'b0, 2, 0, 32'hFFFF_FFF6, 1'b0);
        run(12, "R4 repeat 3-bit masked");
    endtask

    // R5: 7-stage pseudorandom
    task automatic t_prbs7();
        do_load(1'b0, 1'b1, 6, 5, 32'h0000_0055, 1'b0);
        run(140, "R5 prbs 7-stage");
    endtask

    // R6: zero seed replaced
    task automatic t_prbs_zero_seed();
        int ones = 0;
        do_load(1'b0, 1'b1, 4, 2, 32'h0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            logic b;
            @(negedge clk);
            ref_step(b);
            chk("R6 zero seed", dout, b);
            ones += int'(dout);
        end
        checks++;
        if (ones == 0) begin
            fails++;
            $display("FAIL R6 ones count: actual=%0d expected>0", ones);
        end
    endtask

    // R7, R8, R3: capped mode with a long initial zero run
    task automatic t_qrss();
        int run0 = 0, worst = 0;
        do_load(1'b1, 1'b1, 3, 1, 32'h0000_0001, 1'b0);
        for (int i = 0; i < 300; i++) begin
            logic b;
            @(negedge clk);
            ref_step(b);
            chk("R7 R3 qrss sequence", dout, b);
            if (!dout) run0++; else run0 = 0;
            if (run0 > worst) worst = run0;
        end
        checks++;
        if (worst != 13) begin
            fails++;
            $display("FAIL R8 longest zero run: actual=%0d expected=13", worst);
        end
    endtask

    // R9: inverted output, then mid-run toggle
    task automatic t_invert();
        invert = 1'b1;
        do_load(1'b0, 1'b1, 6, 5, 32'h0000_0013, 1'b0);
        run(20, "R9 inverted prbs");
        invert = 1'b0;
        run(10, "R9 after clearing invert");
    endtask

    // R2: load held high while inputs change
    task automatic t_hold();
        do_load(1'b0, 1'b0, 7, 0, 32'h0000_00F0, 1'b1);
        run(5, "R2 before change");
        @(negedge clk);
        begin logic b; ref_step(b); chk("R2 hold", dout, b); end
        cfg_word = 32'h0000_0000; cfg_len = 5'd3; cfg_prbs_sel = 1'b1;
        run(20, "R2 held load ignores inputs");
        load_req = 1'b0;
        cfg_word = 32'h0000_0001;
        run(10, "R2 low load ignores inputs");
        do_load(1'b0, 1'b0, 3, 0, 32'h0000_0009, 1'b0);
        run(8, "R1 reload after release");
    endtask

    initial begin
        t_reset();
        t_repeat_long();
        t_repeat_short();
        t_prbs7();
        t_prbs_zero_seed();
        t_qrss();
        t_invert();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule